// File: doc/BRIEF.md
# Single-Counter Complementary PWM Generator

This block turns an N-bit duty word into a pulse-width-modulated output. It uses one down-counter to time both the high and the low part of each switching period. When a period begins, the counter is loaded with the duty word and the output goes high. When the counter reaches zero, the output goes low and the counter is reloaded with the bitwise inverse of the same word. When that second count reaches zero, the period ends and the next word is taken. The two counts always add up to the same total, so the period is fixed at 2^N+1 clocks and only the split between high and low changes.

A controller upstream presents the duty word as a plain level on `duty_i`. The block drives `cyc_start_o` for one clock, and the duty word is captured on the rising edge that ends that clock. The controller can use this pulse as its update strobe. The generator never stalls and never waits for its input, so there is no valid/ready pair and no back-pressure. The word is taken exactly once per period, and the controller has the whole period to prepare the next one. Reset is synchronous and active high.

Top module: `pwm_single_cnt`

## Requirements
- R1: While `rst` is high, `pwm_o` and `cyc_start_o` are both low.
- R2: In the first clock after `rst` is released, `cyc_start_o` is high and `pwm_o` is still low. On the next rising edge `pwm_o` goes high.
- R3: For a captured duty word D, `pwm_o` is high for exactly D+1 consecutive clocks.
- R4: After the high interval, `pwm_o` is low for exactly 2^N−D clocks. This is the inverse of D plus one.
- R5: The distance between two successive `cyc_start_o` pulses is always 2^N+1 clocks, whatever D is.
- R6: `cyc_start_o` is high for one clock per period, during the last low clock. `pwm_o` rises on the edge right after it, and `cyc_start_o` is never high while `pwm_o` is high.
- R7: `duty_i` is sampled only on the rising edge that ends a `cyc_start_o` clock. Changing it at any other time has no effect on the current period's high or low length.
- R8: At the extremes: D=0 gives one high clock and 2^N low clocks, and D=2^N−1 gives 2^N high clocks and one low clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | DUTY_W | Duty word, sampled when a period begins |
| pwm_o | output | 1 | Modulated output |
| cyc_start_o | output | 1 | One-clock pulse: the duty word is taken at the end of this clock |

## Verification
The bound checker watches every cycle. It checks that the start pulse is always a single clock followed by a rising output. It checks that consecutive pulses are always 2^N+1 clocks apart. It checks that each high run matches the duty word seen at the latest start pulse.

The bench is needed for what the checker cannot show. It sweeps every duty word of a 4-bit configuration and measures the exact high and low lengths against values computed arithmetically. It covers both extreme codes. It changes the duty word in the middle of a period and shows that this has no effect on that period. It also checks the reset and release sequence.

// File: rtl/pwm_sc_pkg.sv
package pwm_sc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_e;

endpackage

// File: rtl/pwm_duty_hold.sv
module pwm_duty_hold #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] duty_q
);

  // Keeps the word of the current period, so the inverse reload ignores later input changes.
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= '0;
    end else if (capture) begin
      duty_q <= duty_i;
    end
  end

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int DUTY_W = 8,
  parameter int CNT_W  = DUTY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_duty,
  input  logic              load_comp,
  input  logic [DUTY_W-1:0] duty_now,
  input  logic [DUTY_W-1:0] duty_held,
  output logic              cnt_zero
);

  localparam int PAD = CNT_W - DUTY_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_ext;
  logic [CNT_W-1:0] comp_ext;
  logic [DUTY_W-1:0] comp_w;

  assign comp_w = ~duty_held;

  generate
    if (PAD > 0) begin : g_pad
      assign duty_ext = {{PAD{1'b0}}, duty_now};
      assign comp_ext = {{PAD{1'b0}}, comp_w};
    end else begin : g_flat
      assign duty_ext = duty_now[CNT_W-1:0];
      assign comp_ext = comp_w[CNT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_duty) begin
      cnt_q <= duty_ext;
    end else if (load_comp) begin
      cnt_q <= comp_ext;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl
  import pwm_sc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cnt_zero,
  output logic   load_duty,
  output logic   load_comp,
  output logic   pwm_q,
  output phase_e phase_q
);

  assign load_duty = (phase_q == PH_IDLE) || ((phase_q == PH_OFF) && cnt_zero);
  assign load_comp = (phase_q == PH_ON) && cnt_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pwm_q   <= 1'b0;
    end else if (load_duty) begin
      phase_q <= PH_ON;
      pwm_q   <= 1'b1;
    end else if (load_comp) begin
      phase_q <= PH_OFF;
      pwm_q   <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_single_cnt.sv
module pwm_single_cnt
  import pwm_sc_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter int CNT_W  = DUTY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o,
  output logic              cyc_start_o
);

  logic              load_duty;
  logic              load_comp;
  logic              cnt_zero;
  logic              pwm_q;
  phase_e            phase_q;
  logic [DUTY_W-1:0] duty_q;

  pwm_phase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cnt_zero  (cnt_zero),
    .load_duty (load_duty),
    .load_comp (load_comp),
    .pwm_q     (pwm_q),
    .phase_q   (phase_q)
  );

  pwm_duty_hold #(.DUTY_W(DUTY_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (load_duty),
    .duty_i  (duty_i),
    .duty_q  (duty_q)
  );

  pwm_down_counter #(.DUTY_W(DUTY_W), .CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load_duty (load_duty),
    .load_comp (load_comp),
    .duty_now  (duty_i),
    .duty_held (duty_q),
    .cnt_zero  (cnt_zero)
  );

  assign pwm_o       = pwm_q;
  assign cyc_start_o = load_duty & ~rst;

endmodule

// File: rtl/pwm_single_cnt_chk.sv
module pwm_single_cnt_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DUTY_W-1:0] duty_i,
  input logic              pwm_o,
  input logic              cyc_start_o
);

  localparam int PER_W = DUTY_W + 2;
  localparam logic [PER_W-1:0] PERIOD = PER_W'((1 << DUTY_W) + 1);

  logic [PER_W-1:0]  per_cnt;
  logic [PER_W-1:0]  hi_cnt;
  logic [DUTY_W-1:0] cap_duty;
  logic              seen_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt    <= '0;
      hi_cnt     <= '0;
      cap_duty   <= '0;
      seen_start <= 1'b0;
    end else begin
      per_cnt <= cyc_start_o ? PER_W'(1) : per_cnt + 1'b1;
      hi_cnt  <= cyc_start_o ? '0 : hi_cnt + PER_W'(pwm_o);
      if (cyc_start_o) begin
        cap_duty   <= duty_i;
        seen_start <= 1'b1;
      end
    end
  end

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !pwm_o);

  assert_start_then_rise_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_start_o |=> (pwm_o && !cyc_start_o));

  assert_start_not_high_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_start_o |-> !pwm_o);

  assert_fixed_period_R5: assert property (@(posedge clk) disable iff (rst)
    (cyc_start_o && seen_start) |-> (per_cnt == PERIOD));

  assert_high_len_R3: assert property (@(posedge clk) disable iff (rst)
    (!pwm_o && $past(pwm_o) && seen_start) |-> (hi_cnt == PER_W'(cap_duty) + 1'b1));

endmodule

bind pwm_single_cnt pwm_single_cnt_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .duty_i      (duty_i),
  .pwm_o       (pwm_o),
  .cyc_start_o (cyc_start_o)
);

// File: tb/pwm_single_cnt_tb.sv
module pwm_single_cnt_tb;

  localparam int N    = 4;
  localparam int FULL = 1 << N;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] duty_i = '0;
  logic         pwm_o;
  logic         cyc_start_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_single_cnt #(.DUTY_W(N)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .duty_i      (duty_i),
    .pwm_o       (pwm_o),
    .cyc_start_o (cyc_start_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One period: sets D, waits for the start clock, measures high and low runs.
  task automatic run_period(input int d, input bit disturb);
    int hi;
    int lo;
    int start_in_hi;
    duty_i = N'(d);
    while (!cyc_start_o) @(negedge clk);
    check("R6 start with pwm low", int'(pwm_o), 0);
    @(negedge clk);
    hi = 0;
    start_in_hi = 0;
    while (pwm_o && hi <= FULL + 2) begin
      if (disturb) duty_i = N'(~d);
      if (cyc_start_o) start_in_hi++;
      hi++;
      @(negedge clk);
    end
    lo = 0;
    while (lo <= FULL + 2) begin
      if (disturb) duty_i = N'(d + 5);
      lo++;
      if (cyc_start_o) break;
      @(negedge clk);
    end
    if (disturb) begin
      check("R7 high length with mid-period change", hi, d + 1);
      check("R7 low length with mid-period change", lo, FULL - d);
    end else begin
      check("R3 high length", hi, d + 1);
      check("R4 low length", lo, FULL - d);
    end
    check("R5 period", hi + lo, FULL + 1);
    check("R6 no start while high", start_in_hi, 0);
    if (d == 0) check("R8 zero code high length", hi, 1);
    if (d == FULL - 1) check("R8 full code low length", lo, 1);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check("R1 pwm in reset", int'(pwm_o), 0);
      check("R1 start in reset", int'(cyc_start_o), 0);
    end
    duty_i = N'(3);
    rst = 1'b0;
    #1;
    check("R2 start after release", int'(cyc_start_o), 1);
    check("R2 pwm after release", int'(pwm_o), 0);
    @(negedge clk);
    check("R2 pwm rises", int'(pwm_o), 1);
    check("R2 start one clock", int'(cyc_start_o), 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    while (pwm_o) @(negedge clk);
    for (int d = 0; d < FULL; d++) run_period(d, 1'b0);
    for (int d = FULL - 1; d >= 0; d -= 3) run_period(d, 1'b1);
    run_period(0, 1'b0);
    run_period(FULL - 1, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule